// File: doc/BRIEF.md
# Multichannel Audio Slot Serializer

The block takes up to four 24-bit capture samples and shifts them out, MSB first, on one serial data line. It frames them as a two-slot stereo stream or as a time-division stream of 2, 4, 8 or 16 slots. The bit-clock edges arrive as two single-cycle strobes in the system clock domain, one for each edge. A configuration bit picks which of the two strobes launches data. A frame-start strobe, given on the launching strobe of the frame's first bit-clock, marks the frame boundary. The block also produces a frame-sync level that is either 50% duty or a one-bit-clock pulse, with selectable polarity.

Configuration inputs set the alignment (I2S one-bit delay, left-justified, or right-justified at 16 or 24 bits), the slot width and the sample width. They also place each channel into any slot through a 4-bit slot number, choose which channels drive, and say whether slots that no channel owns float or carry zeros. A mute input clears all sample bits. Two controllers driving the same slot are resolved to the lower channel number, and a flag reports the conflict.

There are two controller states. WAIT holds the line quiet. RUN serializes. The transition WAIT→RUN (`start`) fires on the first launching strobe that carries the frame-start strobe. RUN has only its self-loop (`stay`), and every later frame-start strobe re-aligns the frame counters.

Top module: `tdm_serializer`

## Requirements
- R1: After reset `sdata`, `sdata_oe`, `fsync` and `map_clash` are 0. While in WAIT, every launching strobe drives `sdata`=0 and `sdata_oe`=0 and sets `fsync` to the `cfg_lr_inv` value.
- R2: The launching strobe is `bclk_rise` when `cfg_bclk_fall`=0 and `bclk_fall` when it is 1. `sdata`, `sdata_oe` and `fsync` update one clock after a launching strobe and hold otherwise.
- R3: `cfg_mode` gives the slot count: 0 and 1 give 2 slots, 2 gives 4, 3 gives 8, 4 gives 16, and other codes give 2. A frame is slot count × slot width bit-clocks long.
- R4: `cfg_slot_w` gives the slot width in bit-clocks: 0 gives 32, 1 gives 24, 2 gives 16, and 3 gives 32.
- R5: `cfg_fmt`=1 (left-justified) puts a sample's MSB on the frame-start bit-clock. `cfg_fmt`=0 (I2S) delays all data by one bit-clock. The bit-clock carrying the frame-start strobe then sends the last bit of the last slot, taken from the newly latched sample set.
- R6: `cfg_fmt`=2 and 3 right-justify a 24-bit and a 16-bit sample (sample bits 23:8 for 16) in each slot. The leading bits are zero. If the slot is narrower than the sample, the sample's MSBs fill the slot.
- R7: In formats 0 and 1, `cfg_short`=1 sends sample bits 23:8 and `cfg_short`=0 sends all 24 bits, MSB first. The sample is followed by zeros up to the slot end, or cut at the slot end.
- R8: Channel c's slot number is `cfg_slot_map[4c+3:4c]`. A channel is sent only if `cfg_drive[c]`=1, and a slot number at or above the slot count is never sent.
- R9: A slot owned by no enabled channel gives `sdata_oe`=0 when `cfg_hiz`=1. When `cfg_hiz`=0 it gives `sdata_oe`=1 and `sdata`=0. Owned slots always drive `sdata_oe`=1.
- R10: When two enabled channels share a slot, the lower-numbered channel is sent, and `map_clash` is 1 one clock after such a configuration is applied.
- R11: `cfg_mute`=1 makes every transmitted bit 0 without changing `sdata_oe`.
- R12: With `cfg_pulse`=0, `fsync` is high in the first half of the frame's bit-clocks. With `cfg_pulse`=1, it is high only for the bit-clock carrying the frame-start strobe. `cfg_lr_inv`=1 inverts `fsync` in both cases.
- R13: All four samples are latched at the frame-start strobe, so a change on `ch_sample` during a frame does not alter that frame's bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_rise | input | 1 | Strobe for a rising bit-clock edge |
| bclk_fall | input | 1 | Strobe for a falling bit-clock edge |
| frame_start | input | 1 | First bit-clock of a frame, given with the launching strobe |
| ch_sample | input | 96 | Channel c sample in bits 24c+23:24c |
| cfg_fmt | input | 2 | Alignment: 0 I2S, 1 left, 2 right 24, 3 right 16 |
| cfg_mode | input | 3 | Slot count code |
| cfg_slot_w | input | 2 | Slot width code |
| cfg_short | input | 1 | 16-bit samples in formats 0 and 1 |
| cfg_pulse | input | 1 | One-bit-clock frame-sync pulse |
| cfg_lr_inv | input | 1 | Invert frame sync |
| cfg_bclk_fall | input | 1 | Launch data on the falling-edge strobe |
| cfg_slot_map | input | 16 | Four 4-bit slot numbers, channel 0 in the low nibble |
| cfg_drive | input | 4 | Per-channel drive enable |
| cfg_hiz | input | 1 | Float slots that no channel owns |
| cfg_mute | input | 1 | Zero all sample bits |
| sdata | output | 1 | Serial data |
| sdata_oe | output | 1 | Output enable for serial data |
| fsync | output | 1 | Frame-sync level |
| map_clash | output | 1 | Two enabled channels share a slot |

## Verification
The properties take for granted that frame-start strobes only appear together with a launching strobe. They also assume that configuration inputs change only between frames, with no launching strobe pending. The stimulus meets both: every frame-start is issued inside the launching half of a bit-clock, and reconfiguration happens only in a quiet clock after the opposite-edge strobe. Frames are also driven back to back at exactly slot count × slot width bit-clocks, which matches what the 50% frame-sync expectation relies on.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;

    typedef enum logic [1:0] {
        FMT_I2S     = 2'd0,
        FMT_LEFT    = 2'd1,
        FMT_RIGHT24 = 2'd2,
        FMT_RIGHT16 = 2'd3
    } tdm_fmt_e;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_RUN  = 1'b1
    } tdm_state_e;

    // slot width in bit-clocks (R4)
    function automatic logic [5:0] slot_len(input logic [1:0] code);
        case (code)
            2'd1:    return 6'd24;
            2'd2:    return 6'd16;
            default: return 6'd32;
        endcase
    endfunction

    // slots per frame (R3)
    function automatic logic [4:0] slot_total(input logic [2:0] mode);
        case (mode)
            3'd2:    return 5'd4;
            3'd3:    return 5'd8;
            3'd4:    return 5'd16;
            default: return 5'd2;
        endcase
    endfunction

endpackage

// File: rtl/tdm_pos_ctr.sv
module tdm_pos_ctr #(
    parameter int BIT_W  = 6,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              load,
    input  logic [BIT_W-1:0]  load_bit,
    input  logic [SLOT_W-1:0] load_slot,
    input  logic [BIT_W-1:0]  len,
    input  logic [SLOT_W-1:0] total,
    output logic [BIT_W-1:0]  nxt_bit,
    output logic [SLOT_W-1:0] nxt_slot
);
    logic [BIT_W-1:0]  bit_q;
    logic [SLOT_W-1:0] slot_q;

    always_comb begin
        if (load) begin
            nxt_bit  = load_bit;
            nxt_slot = load_slot;
        end else if ((bit_q + 1'b1) >= len) begin
            nxt_bit  = '0;
            nxt_slot = (slot_q + 1'b1) & (total - 1'b1);
        end else begin
            nxt_bit  = bit_q + 1'b1;
            nxt_slot = slot_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= '0;
            slot_q <= '0;
        end else if (step) begin
            bit_q  <= nxt_bit;
            slot_q <= nxt_slot;
        end
    end
endmodule

// File: rtl/tdm_slot_owner.sv
module tdm_slot_owner #(
    parameter int CH_N   = 4,
    parameter int MAP_W  = 4,
    parameter int SLOT_W = MAP_W + 1,
    localparam int CH_W  = (CH_N > 1) ? $clog2(CH_N) : 1
) (
    input  logic [SLOT_W-1:0]     slot,
    input  logic [CH_N*MAP_W-1:0] slot_map,
    input  logic [CH_N-1:0]       drive,
    output logic                  hit,
    output logic [CH_W-1:0]       owner,
    output logic                  clash
);
    logic [CH_N-1:0] match;

    for (genvar c = 0; c < CH_N; c++) begin : g_match
        assign match[c] = drive[c] &&
                          (SLOT_W'(slot_map[c*MAP_W +: MAP_W]) == slot);
    end

    // lowest channel number wins (R10)
    always_comb begin
        hit   = 1'b0;
        owner = '0;
        for (int c = CH_N - 1; c >= 0; c--) begin
            if (match[c]) begin
                hit   = 1'b1;
                owner = CH_W'(c);
            end
        end
    end

    always_comb begin
        clash = 1'b0;
        for (int i = 0; i < CH_N; i++) begin
            for (int j = i + 1; j < CH_N; j++) begin
                if (drive[i] && drive[j] &&
                    slot_map[i*MAP_W +: MAP_W] == slot_map[j*MAP_W +: MAP_W])
                    clash = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdm_bit_pick.sv
module tdm_bit_pick
    import tdm_ser_pkg::*;
#(
    parameter int SMP_W   = 24,
    parameter int SHORT_W = 16,
    parameter int BIT_W   = 6
) (
    input  logic [SMP_W-1:0] sample,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic [BIT_W-1:0] len,
    input  tdm_fmt_e         fmt,
    input  logic             short_sel,
    output logic             bit_o
);
    int used_w;
    int lead;
    int k;

    always_comb begin
        // sample length in this slot (R6, R7)
        if (fmt == FMT_RIGHT16)      used_w = SHORT_W;
        else if (fmt == FMT_RIGHT24) used_w = SMP_W;
        else if (short_sel)          used_w = SHORT_W;
        else                         used_w = SMP_W;
        lead = 0;
        if ((fmt inside {FMT_RIGHT24, FMT_RIGHT16}) && int'(len) > used_w)
            lead = int'(len) - used_w;
        k     = int'(bit_idx) - lead;
        bit_o = 1'b0;
        if (k >= 0 && k < used_w)
            bit_o = sample[SMP_W-1-k];
    end
endmodule

// File: rtl/tdm_serializer.sv
module tdm_serializer
    import tdm_ser_pkg::*;
#(
    parameter int CH_N    = 4,
    parameter int SMP_W   = 24,
    parameter int SHORT_W = 16,
    parameter int MAP_W   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bclk_rise,
    input  logic                  bclk_fall,
    input  logic                  frame_start,
    input  logic [CH_N*SMP_W-1:0] ch_sample,
    input  logic [1:0]            cfg_fmt,
    input  logic [2:0]            cfg_mode,
    input  logic [1:0]            cfg_slot_w,
    input  logic                  cfg_short,
    input  logic                  cfg_pulse,
    input  logic                  cfg_lr_inv,
    input  logic                  cfg_bclk_fall,
    input  logic [CH_N*MAP_W-1:0] cfg_slot_map,
    input  logic [CH_N-1:0]       cfg_drive,
    input  logic                  cfg_hiz,
    input  logic                  cfg_mute,
    output logic                  sdata,
    output logic                  sdata_oe,
    output logic                  fsync,
    output logic                  map_clash
);
    localparam int SLOT_W = MAP_W + 1;
    localparam int BIT_W  = 6;
    localparam int CH_W   = (CH_N > 1) ? $clog2(CH_N) : 1;

    tdm_state_e        state_q, state_d;
    tdm_fmt_e          fmt;
    logic              launch, go, i2s;
    logic [BIT_W-1:0]  len;
    logic [SLOT_W-1:0] total;
    logic [BIT_W-1:0]  raw_bit, dat_bit;
    logic [SLOT_W-1:0] raw_slot, dat_slot;
    logic              hit, clash, pick, fs_level;
    logic [CH_W-1:0]   owner;
    logic [SMP_W-1:0]  smp_q [CH_N];
    logic [SMP_W-1:0]  cur_smp;

    // launching edge select (R2)
    assign launch = cfg_bclk_fall ? bclk_fall : bclk_rise;
    assign go     = launch && frame_start;
    assign fmt    = tdm_fmt_e'(cfg_fmt);
    assign i2s    = (fmt == FMT_I2S);
    assign len    = slot_len(cfg_slot_w);
    assign total  = SLOT_W'(slot_total(cfg_mode));

    // undelayed frame position, drives frame sync (R12)
    tdm_pos_ctr #(.BIT_W(BIT_W), .SLOT_W(SLOT_W)) u_raw_ctr (
        .clk(clk), .rst_n(rst_n), .step(launch), .load(go),
        .load_bit('0), .load_slot('0), .len(len), .total(total),
        .nxt_bit(raw_bit), .nxt_slot(raw_slot)
    );

    // data position, one bit-clock late in I2S (R5)
    tdm_pos_ctr #(.BIT_W(BIT_W), .SLOT_W(SLOT_W)) u_dat_ctr (
        .clk(clk), .rst_n(rst_n), .step(launch), .load(go),
        .load_bit(i2s ? len - 1'b1 : '0),
        .load_slot(i2s ? total - 1'b1 : '0),
        .len(len), .total(total),
        .nxt_bit(dat_bit), .nxt_slot(dat_slot)
    );

    tdm_slot_owner #(.CH_N(CH_N), .MAP_W(MAP_W), .SLOT_W(SLOT_W)) u_owner (
        .slot(dat_slot), .slot_map(cfg_slot_map), .drive(cfg_drive),
        .hit(hit), .owner(owner), .clash(clash)
    );

    // coherent sample set per frame (R13)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < CH_N; c++) smp_q[c] <= '0;
        end else if (go) begin
            for (int c = 0; c < CH_N; c++) smp_q[c] <= ch_sample[c*SMP_W +: SMP_W];
        end
    end

    assign cur_smp = go ? ch_sample[owner*SMP_W +: SMP_W] : smp_q[owner];

    tdm_bit_pick #(.SMP_W(SMP_W), .SHORT_W(SHORT_W), .BIT_W(BIT_W)) u_pick (
        .sample(cur_smp), .bit_idx(dat_bit), .len(len), .fmt(fmt),
        .short_sel(cfg_short), .bit_o(pick)
    );

    assign fs_level = cfg_pulse ? frame_start : (raw_slot < (total >> 1));

    // next state (R1: start on first framed launch)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (go) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // outputs (R9, R11, R12)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdata     <= 1'b0;
            sdata_oe  <= 1'b0;
            fsync     <= 1'b0;
            map_clash <= 1'b0;
        end else begin
            map_clash <= clash;
            if (launch) begin
                unique case (state_d)
                    ST_WAIT: begin
                        sdata    <= 1'b0;
                        sdata_oe <= 1'b0;
                        fsync    <= cfg_lr_inv;
                    end
                    ST_RUN: begin
                        sdata    <= hit & ~cfg_mute & pick;
                        sdata_oe <= hit | ~cfg_hiz;
                        fsync    <= fs_level ^ cfg_lr_inv;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/tdm_serializer_chk.sv
module tdm_serializer_chk #(
    parameter int CH_N  = 4,
    parameter int MAP_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bclk_rise,
    input logic                  bclk_fall,
    input logic                  frame_start,
    input logic                  cfg_pulse,
    input logic                  cfg_lr_inv,
    input logic                  cfg_bclk_fall,
    input logic [CH_N*MAP_W-1:0] cfg_slot_map,
    input logic [CH_N-1:0]       cfg_drive,
    input logic                  cfg_hiz,
    input logic                  cfg_mute,
    input logic                  sdata,
    input logic                  sdata_oe,
    input logic                  fsync,
    input logic                  map_clash
);
    logic launch;
    assign launch = cfg_bclk_fall ? bclk_fall : bclk_rise;

    p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> ($stable(sdata) && $stable(sdata_oe) && $stable(fsync)));

    p_mute_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && cfg_mute) |=> !sdata);

    p_hiz_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && cfg_hiz && cfg_drive == '0) |=> !sdata_oe);

    p_pulse_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && cfg_pulse && !frame_start) |=> (fsync == $past(cfg_lr_inv)));

    p_pulse_mark_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && cfg_pulse && frame_start) |=> (fsync != $past(cfg_lr_inv)));

    p_clash_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_drive[0] && cfg_drive[1] &&
         cfg_slot_map[MAP_W-1:0] == cfg_slot_map[2*MAP_W-1:MAP_W]) |=> map_clash);
endmodule

bind tdm_serializer tdm_serializer_chk #(.CH_N(CH_N), .MAP_W(MAP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
    .frame_start(frame_start), .cfg_pulse(cfg_pulse), .cfg_lr_inv(cfg_lr_inv),
    .cfg_bclk_fall(cfg_bclk_fall), .cfg_slot_map(cfg_slot_map),
    .cfg_drive(cfg_drive), .cfg_hiz(cfg_hiz), .cfg_mute(cfg_mute),
    .sdata(sdata), .sdata_oe(sdata_oe), .fsync(fsync), .map_clash(map_clash)
);

// File: tb/tdm_serializer_test.sv
module tdm_serializer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bclk_rise, bclk_fall, frame_start;
    logic [95:0] ch_sample;
    logic [1:0]  cfg_fmt, cfg_slot_w;
    logic [2:0]  cfg_mode;
    logic        cfg_short, cfg_pulse, cfg_lr_inv, cfg_bclk_fall, cfg_hiz, cfg_mute;
    logic [15:0] cfg_slot_map;
    logic [3:0]  cfg_drive;
    logic        sdata, sdata_oe, fsync, map_clash;

    always #5 clk = ~clk;

    tdm_serializer uut (
        .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
        .frame_start(frame_start), .ch_sample(ch_sample), .cfg_fmt(cfg_fmt),
        .cfg_mode(cfg_mode), .cfg_slot_w(cfg_slot_w), .cfg_short(cfg_short),
        .cfg_pulse(cfg_pulse), .cfg_lr_inv(cfg_lr_inv), .cfg_bclk_fall(cfg_bclk_fall),
        .cfg_slot_map(cfg_slot_map), .cfg_drive(cfg_drive), .cfg_hiz(cfg_hiz),
        .cfg_mute(cfg_mute), .sdata(sdata), .sdata_oe(sdata_oe), .fsync(fsync),
        .map_clash(map_clash)
    );

    typedef struct {
        logic [2:0] val;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    int         checks = 0;
    int         errors = 0;
    logic       due = 1'b0;
    logic       have_last = 1'b0;
    logic [2:0] last_val = 3'b000;
    bit         finished = 1'b0;

    // a launching strobe seen at this edge means a result is due (R2)
    always @(posedge clk) due <= rst_n && (cfg_bclk_fall ? bclk_fall : bclk_rise);

    // monitor: pops and compares {sdata, sdata_oe, fsync}
    always @(negedge clk) begin
        if (rst_n && due) begin
            if (sb_q.size() == 0) begin
                errors++; checks++;
                $display("FAIL R2 unexpected result got %b%b%b exp none", sdata, sdata_oe, fsync);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if ({sdata, sdata_oe, fsync} !== e.val) begin
                    errors++;
                    $display("FAIL %s got %b exp %b", e.tag, {sdata, sdata_oe, fsync}, e.val);
                end
                last_val  = e.val;
                have_last = 1'b1;
            end
        end else if (rst_n && have_last) begin
            checks++;
            if ({sdata, sdata_oe, fsync} !== last_val) begin
                errors++;
                $display("FAIL R2 hold got %b exp %b", {sdata, sdata_oe, fsync}, last_val);
            end
        end
    end

    function automatic int f_sw();
        return (cfg_slot_w == 2'd2) ? 16 : (cfg_slot_w == 2'd1) ? 24 : 32;
    endfunction

    function automatic int f_ns();
        case (cfg_mode)
            3'd2: return 4;
            3'd3: return 8;
            3'd4: return 16;
            default: return 2;
        endcase
    endfunction

    // reference: {sdata, sdata_oe, fsync} for raw bit-clock n of a frame
    function automatic logic [2:0] model(int n, logic [95:0] smp, bit strobe);
        int sw, frame, p, s, b, owner, used;
        logic [23:0] d, dl;
        logic [31:0] word;
        logic sd, oe, fs;
        sw    = f_sw();
        frame = sw * f_ns();
        p     = (cfg_fmt == 2'd0) ? (n + frame - 1) % frame : n;
        s     = p / sw;
        b     = p % sw;
        owner = -1;
        for (int c = 0; c < 4; c++)
            if (owner < 0 && cfg_drive[c] && int'(cfg_slot_map[4*c +: 4]) == s) owner = c;
        if (owner < 0) begin
            sd = 1'b0;
            oe = ~cfg_hiz;
        end else begin
            oe   = 1'b1;
            d    = smp[24*owner +: 24];
            used = (cfg_fmt == 2'd3) ? 16 : (cfg_fmt == 2'd2) ? 24 : (cfg_short ? 16 : 24);
            dl   = (used == 16) ? {8'h00, d[23:8]} : d;
            if (sw >= used) word = cfg_fmt[1] ? 32'(dl) : (32'(dl) << (sw - used));
            else            word = 32'(dl) >> (used - sw);
            sd = cfg_mute ? 1'b0 : word[sw-1-b];
        end
        fs = (cfg_pulse ? strobe : (n < frame / 2)) ^ cfg_lr_inv;
        return {sd, oe, fs};
    endfunction

    // one bit-clock: launching half then opposite half
    task automatic tick(bit strobe, logic [2:0] e, string tag);
        exp_t it;
        @(negedge clk);
        bclk_rise   = ~cfg_bclk_fall;
        bclk_fall   = cfg_bclk_fall;
        frame_start = strobe;
        it.val = e;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        bclk_rise   = cfg_bclk_fall;
        bclk_fall   = ~cfg_bclk_fall;
        frame_start = 1'b0;
    endtask

    task automatic quiet();
        @(negedge clk);
        bclk_rise = 1'b0;
        bclk_fall = 1'b0;
        frame_start = 1'b0;
    endtask

    task automatic run_frame(logic [95:0] smp, string tag, bit mid);
        int frame;
        frame = f_sw() * f_ns();
        for (int n = 0; n < frame; n++) begin
            if (n == 0) ch_sample = smp;
            if (mid && n == 1) ch_sample = ~smp;
            tick(n == 0, model(n, smp, n == 0), tag);
        end
    endtask

    task automatic check_bit(logic got, logic exp, string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b exp %b", tag, got, exp);
        end
    endtask

    localparam logic [95:0] SA = {24'hC3A5F0, 24'h81FF7E, 24'h5A0F96, 24'hF00D13};
    localparam logic [95:0] SB = {24'h123456, 24'hFEDCBA, 24'h800001, 24'h7FFFFE};

    initial begin
        rst_n = 1'b0;
        bclk_rise = 1'b0; bclk_fall = 1'b0; frame_start = 1'b0;
        ch_sample = '0;
        cfg_fmt = 2'd1; cfg_mode = 3'd2; cfg_slot_w = 2'd0; cfg_short = 1'b0;
        cfg_pulse = 1'b0; cfg_lr_inv = 1'b0; cfg_bclk_fall = 1'b0;
        cfg_slot_map = 16'h3210; cfg_drive = 4'hF; cfg_hiz = 1'b0; cfg_mute = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_bit(sdata, 1'b0, "R1 sdata");
        check_bit(sdata_oe, 1'b0, "R1 sdata_oe");
        check_bit(fsync, 1'b0, "R1 fsync");
        check_bit(map_clash, 1'b0, "R1 map_clash");
        // R1 quiet in WAIT
        tick(1'b0, 3'b000, "R1 wait");
        tick(1'b0, 3'b000, "R1 wait");
        // left-justified TDM4, back to back (R3 R5 R8)
        run_frame(SA, "R3/R5/R8 lj tdm4", 1'b0);
        run_frame(SB, "R3/R5/R8 lj tdm4", 1'b0);
        quiet();
        // I2S stereo (R5)
        cfg_fmt = 2'd0; cfg_mode = 3'd0;
        run_frame(SA, "R5 i2s", 1'b0);
        run_frame(SB, "R5 i2s", 1'b0);
        quiet();
        // right-justified (R6)
        cfg_fmt = 2'd2; cfg_mode = 3'd2;
        run_frame(SA, "R6 rj24", 1'b0);
        quiet();
        cfg_fmt = 2'd3;
        run_frame(SB, "R6 rj16", 1'b0);
        quiet();
        cfg_slot_w = 2'd2;
        run_frame(SA, "R6 rj24-in-16", 1'b0);
        quiet();
        // slot width and sample width (R4 R7)
        cfg_fmt = 2'd1; cfg_slot_w = 2'd1; cfg_mode = 3'd1;
        run_frame(SA, "R4 sw24", 1'b0);
        quiet();
        cfg_slot_w = 2'd2; cfg_mode = 3'd3; cfg_short = 1'b1;
        run_frame(SB, "R4/R7 sw16 short", 1'b0);
        quiet();
        cfg_slot_w = 2'd0; cfg_mode = 3'd2;
        run_frame(SA, "R7 short in 32", 1'b0);
        quiet();
        cfg_short = 1'b0; cfg_slot_w = 2'd2; cfg_mode = 3'd4;
        run_frame(SB, "R3/R7 tdm16 cut", 1'b0);
        quiet();
        // remap with float on undriven slots (R8 R9)
        cfg_short = 1'b1; cfg_mode = 3'd3; cfg_slot_map = 16'h9725; cfg_drive = 4'b0111;
        cfg_hiz = 1'b1;
        run_frame(SA, "R8/R9 remap hiz", 1'b0);
        quiet();
        cfg_hiz = 1'b0;
        run_frame(SB, "R9 remap zero", 1'b0);
        quiet();
        // collision (R10)
        cfg_short = 1'b0; cfg_slot_w = 2'd0; cfg_mode = 3'd2;
        cfg_slot_map = 16'h0113; cfg_drive = 4'hF;
        @(negedge clk); @(negedge clk);
        check_bit(map_clash, 1'b1, "R10 flag set");
        run_frame(SA, "R10 lower wins", 1'b0);
        quiet();
        cfg_drive = 4'b1011;
        @(negedge clk); @(negedge clk);
        check_bit(map_clash, 1'b0, "R10 flag clear");
        cfg_slot_map = 16'h3210; cfg_drive = 4'hF;
        // mute (R11)
        cfg_mute = 1'b1;
        run_frame(SA, "R11 mute", 1'b0);
        quiet();
        cfg_mute = 1'b0;
        // pulse sync, inverted, falling launch (R12 R2)
        cfg_pulse = 1'b1; cfg_lr_inv = 1'b1; cfg_bclk_fall = 1'b1;
        run_frame(SB, "R12/R2 pulse inv fall", 1'b0);
        run_frame(SA, "R12/R2 pulse inv fall", 1'b0);
        quiet();
        cfg_pulse = 1'b0;
        run_frame(SA, "R12 half inv", 1'b0);
        quiet();
        cfg_lr_inv = 1'b0; cfg_bclk_fall = 1'b0;
        // coherence (R13)
        run_frame(SB, "R13 latched", 1'b1);
        quiet();
        @(negedge clk); @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R2 pending results got %0d exp 0", sb_q.size());
        end
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog got timeout exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule